// File: doc/BRIEF.md
# T1 Framing Bit Error Density Monitor

This block watches the framing bits of a T1 receive stream and asks the frame search logic to start again when framing errors become too dense. For each framing bit, an upstream comparator presents a one-cycle strobe. With the strobe come a flag that marks the bit as wrong against the expected pattern and a flag that tells a terminal-framing bit (Ft) from a signalling-framing bit (Fs). The monitor keeps a short history of the framing bits it checks. When two errors fall inside the newest N of them, it raises a single-cycle reframe request.

A 2-bit threshold select sets the window length N to 4, 5 or 6, or turns automatic reframing off. The line format decides which framing bits are checked. In extended-superframe mode every framing bit counts. In superframe (D4) mode only Ft bits count, unless the Fs-check enable is set, in which case Fs bits count as well. After a reframe request the history is emptied, so errors that were already counted cannot raise a second request. The block also reports the number of errors in the current window.

Top module: `t1_fbit_density_mon`

## Requirements
- R1: After reset `reframe_req` is 0 and `err_count` is 0.
- R2: With `thresh_sel` = 2'b00, `reframe_req` pulses one cycle after the checked framing bit that brings the errors among the newest 4 checked bits to 2.
- R3: With `thresh_sel` = 2'b01 the window is the newest 5 checked bits. With `thresh_sel` = 2'b10 it is the newest 6 checked bits. Two errors inside the window raise `reframe_req`, and two errors farther apart than the window do not.
- R4: With `thresh_sel` = 2'b11, `reframe_req` never asserts. `err_count` still reports the errors among the newest 6 checked bits.
- R5: With `esf_mode` = 1, every strobed framing bit is checked, whatever the values of `fbit_is_fs` and `fs_chk_en`.
- R6: With `esf_mode` = 0 and `fs_chk_en` = 0, a bit with `fbit_is_fs` = 1 is not checked. It does not shift the history and does not change `err_count`. Bits with `fbit_is_fs` = 0 are checked.
- R7: With `esf_mode` = 0 and `fs_chk_en` = 1, both Ft (`fbit_is_fs` = 0) and Fs (`fbit_is_fs` = 1) bits are checked.
- R8: `err_count` is registered. One cycle after a checked bit, it shows the number of errors among the newest N checked bits.
- R9: In the cycle that `reframe_req` is 1, the history is cleared and `err_count` is 0. For this reason `reframe_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fbit_stb | input | 1 | One-cycle strobe, one per received framing bit |
| fbit_err | input | 1 | 1 when the strobed framing bit differs from the expected value |
| fbit_is_fs | input | 1 | 1 for an Fs bit, 0 for an Ft bit |
| esf_mode | input | 1 | 1 = extended superframe, 0 = D4 superframe |
| fs_chk_en | input | 1 | In D4 mode, 1 = also check Fs bits |
| thresh_sel | input | 2 | Window length: 00 = 4, 01 = 5, 10 = 6, 11 = reframe disabled |
| reframe_req | output | 1 | Single-cycle reframe request |
| err_count | output | 3 | Errors in the current window |

## Verification
The assertions check on every cycle that a request is a lone pulse, that a request coincides with a cleared count, and that no request follows a cycle with the disable code selected. They also check that the count never exceeds the window and that the history stays unchanged unless a checked bit or a clear arrives. Only the bench scenarios can show the rest. That covers the exact window lengths and the cycle in which the request appears. It also covers whether Fs bits in D4 mode are skipped without shifting the history, and whether ESF mode really checks every bit.

// File: rtl/t1fd_pkg.sv
package t1fd_pkg;
  localparam logic [1:0] THR_OFF = 2'b11;

  // Window length selected by the threshold code: base, base+1, base+2; off uses the full depth
  function automatic int unsigned win_len(input logic [1:0] sel, input int unsigned base,
                                          input int unsigned depth);
    int unsigned l;
    if (sel == THR_OFF) l = depth;
    else                l = base + int'(sel);
    if (l > depth) l = depth;
    return l;
  endfunction
endpackage

// File: rtl/t1fd_qualify.sv
module t1fd_qualify (
  input  logic stb_i,
  input  logic is_fs_i,
  input  logic esf_i,
  input  logic fs_en_i,
  output logic chk_o
);
  always_comb begin
    if (!stb_i)       chk_o = 1'b0;
    else if (esf_i)   chk_o = 1'b1;
    else if (is_fs_i) chk_o = fs_en_i;
    else              chk_o = 1'b1;
  end
endmodule

// File: rtl/t1fd_window.sv
module t1fd_window #(
  parameter int unsigned DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_i,
  input  logic             err_i,
  input  logic             clear_i,
  output logic [DEPTH-1:0] hist_q,
  output logic [DEPTH-1:0] hist_d
);
  // bit 0 holds the newest checked framing bit
  always_comb begin
    if (shift_i) hist_d = {hist_q[DEPTH-2:0], err_i};
    else         hist_d = hist_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) hist_q <= '0;
    else                hist_q <= hist_d;
  end

  // R6: unchecked bits leave the history untouched
  a_r6_hold_unchecked: assert property (@(posedge clk) disable iff (rst)
    (!shift_i && !clear_i) |=> (hist_q == $past(hist_q)));
endmodule

// File: rtl/t1fd_popcnt.sv
module t1fd_popcnt #(
  parameter int unsigned DEPTH = 6,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] vec_i,
  input  logic [CW-1:0]    len_i,
  output logic [CW-1:0]    cnt_o
);
  logic [DEPTH-1:0] masked;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_mask
      assign masked[i] = vec_i[i] & (CW'(i) < len_i);
    end
  endgenerate

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < DEPTH; i++) cnt_o = cnt_o + CW'(masked[i]);
  end
endmodule

// File: rtl/t1_fbit_density_mon.sv
module t1_fbit_density_mon #(
  parameter int unsigned DEPTH    = 6,
  parameter int unsigned BASE_LEN = 4,
  parameter int unsigned TRIG     = 2,
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fbit_stb,
  input  logic          fbit_err,
  input  logic          fbit_is_fs,
  input  logic          esf_mode,
  input  logic          fs_chk_en,
  input  logic [1:0]    thresh_sel,
  output logic          reframe_req,
  output logic [CW-1:0] err_count
);
  import t1fd_pkg::*;

  logic             chk;
  logic             fire;
  logic [DEPTH-1:0] hist_q, hist_d;
  logic [CW-1:0]    len, cnt_d;

  t1fd_qualify u_qual (
    .stb_i(fbit_stb), .is_fs_i(fbit_is_fs), .esf_i(esf_mode),
    .fs_en_i(fs_chk_en), .chk_o(chk)
  );

  t1fd_window #(.DEPTH(DEPTH)) u_win (
    .clk(clk), .rst(rst), .shift_i(chk), .err_i(fbit_err),
    .clear_i(fire), .hist_q(hist_q), .hist_d(hist_d)
  );

  assign len = CW'(win_len(thresh_sel, BASE_LEN, DEPTH));

  t1fd_popcnt #(.DEPTH(DEPTH)) u_cnt (
    .vec_i(hist_d), .len_i(len), .cnt_o(cnt_d)
  );

  assign fire = chk && (thresh_sel != THR_OFF) && (cnt_d >= CW'(TRIG));

  always_ff @(posedge clk) begin
    if (rst) begin
      reframe_req <= 1'b0;
      err_count   <= '0;
    end else begin
      reframe_req <= fire;
      err_count   <= fire ? '0 : cnt_d;
    end
  end

  // R9: a request is a lone pulse
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    reframe_req |=> !reframe_req);
  // R9: request coincides with emptied window
  a_r9_count_cleared: assert property (@(posedge clk) disable iff (rst)
    reframe_req |-> (err_count == '0) && (hist_q == '0));
  // R4: no request when the disable code was selected
  a_r4_disabled: assert property (@(posedge clk) disable iff (rst)
    reframe_req |-> ($past(thresh_sel) != THR_OFF));
  // R8: count bounded by window depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    err_count <= CW'(DEPTH));
endmodule

// File: tb/t1_fbit_density_mon_tb.sv
module t1_fbit_density_mon_tb;
  logic clk = 1'b0;
  logic rst;
  logic fbit_stb, fbit_err, fbit_is_fs, esf_mode, fs_chk_en;
  logic [1:0] thresh_sel;
  logic reframe_req;
  logic [2:0] err_count;
  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  t1_fbit_density_mon u_dut (
    .clk(clk), .rst(rst), .fbit_stb(fbit_stb), .fbit_err(fbit_err),
    .fbit_is_fs(fbit_is_fs), .esf_mode(esf_mode), .fs_chk_en(fs_chk_en),
    .thresh_sel(thresh_sel), .reframe_req(reframe_req), .err_count(err_count)
  );

  task automatic check(input string req, input logic exp_r, input int exp_c);
    n_tests++;
    if (reframe_req !== exp_r || err_count !== 3'(exp_c)) begin
      n_fail++;
      $display("FAIL %s: req=%0b cnt=%0d expected req=%0b cnt=%0d",
               req, reframe_req, err_count, exp_r, exp_c);
    end
  endtask

  task automatic do_reset(input logic esf, input logic fsen, input logic [1:0] sel);
    @(negedge clk);
    rst = 1'b1; fbit_stb = 0; fbit_err = 0; fbit_is_fs = 0;
    esf_mode = esf; fs_chk_en = fsen; thresh_sel = sel;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  // drive one framing bit, check outputs one cycle later
  task automatic fbit(input logic fs, input logic err, input logic exp_r,
                      input int exp_c, input string req);
    @(negedge clk);
    fbit_stb = 1; fbit_err = err; fbit_is_fs = fs;
    @(negedge clk);
    fbit_stb = 0; fbit_err = 0;
    check(req, exp_r, exp_c);
  endtask

  task automatic t_reset;
    do_reset(1, 0, 2'b00);
    @(negedge clk);
    check("R1", 0, 0);
  endtask

  task automatic t_len4;
    do_reset(1, 0, 2'b00);
    fbit(0, 1, 0, 1, "R8");
    fbit(0, 0, 0, 1, "R2");
    fbit(0, 0, 0, 1, "R2");
    fbit(0, 0, 0, 1, "R2");
    fbit(0, 1, 0, 1, "R2");   // errors 5 apart: outside 4-bit window
    fbit(0, 0, 0, 1, "R2");
    fbit(0, 1, 1, 0, "R2");   // two in newest 4 -> request, cleared (R9)
    @(negedge clk);
    check("R9", 0, 0);
    fbit(0, 1, 0, 1, "R9");   // stale errors gone
  endtask

  task automatic t_len5;
    do_reset(1, 0, 2'b01);
    fbit(0, 1, 0, 1, "R3");
    for (int i = 0; i < 4; i++) fbit(0, 0, 0, (i < 4) ? 1 : 0, "R3");
    fbit(0, 1, 0, 1, "R3");   // six apart: outside 5-bit window
    fbit(0, 0, 0, 1, "R3");
    fbit(0, 0, 0, 1, "R3");
    fbit(0, 0, 0, 1, "R3");
    fbit(0, 1, 1, 0, "R3");   // within newest 5
  endtask

  task automatic t_len6;
    do_reset(1, 0, 2'b10);
    fbit(0, 1, 0, 1, "R3");
    for (int i = 0; i < 4; i++) fbit(0, 0, 0, 1, "R3");
    fbit(0, 1, 1, 0, "R3");   // 6th bit: inside 6-bit window
  endtask

  task automatic t_off;
    do_reset(1, 0, 2'b11);
    for (int i = 0; i < 8; i++) fbit(0, 1, 0, (i < 6) ? i + 1 : 6, "R4");
    fbit(0, 0, 0, 5, "R4");
  endtask

  task automatic t_esf;
    do_reset(1, 0, 2'b00);
    fbit(1, 1, 0, 1, "R5");   // Fs-flagged bit still checked in ESF
    fbit(1, 1, 1, 0, "R5");
  endtask

  task automatic t_d4_ft_only;
    do_reset(0, 0, 2'b00);
    fbit(0, 1, 0, 1, "R6");
    fbit(1, 1, 0, 1, "R6");   // Fs ignored
    fbit(1, 1, 0, 1, "R6");
    fbit(1, 0, 0, 1, "R6");
    fbit(0, 0, 0, 1, "R6");
    fbit(0, 0, 0, 1, "R6");
    fbit(0, 1, 1, 0, "R6");   // Ft bits: E,C,C,E -> only works if Fs did not shift
  endtask

  task automatic t_d4_fs;
    do_reset(0, 1, 2'b00);
    fbit(1, 1, 0, 1, "R7");
    fbit(0, 0, 0, 1, "R7");
    fbit(1, 1, 1, 0, "R7");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_len4();
        t_len5();
        t_len6();
        t_off();
        t_esf();
        t_d4_ft_only();
        t_d4_fs();
      end
      begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule